// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block holds the interrupt registers of a communications controller. Event pulses from the receive and transmit logic, plus a level that reports that the receive buffer holds at least one frame, are recorded in a status register. A mask register decides which events may be recorded at all. An enable register decides which recorded events drive the single level interrupt output.

Host software reaches the registers over a simple 32-bit register bus with a word address. A write is taken on the rising clock edge while `bus_wr` is high. Read data is a combinational function of `bus_addr` and has no side effects. Enable and mask each have one address that sets the written bits and one that clears them. Writing the status register clears the bits written as 1.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Status bit positions are fixed: bit 0 receive done, bit 1 receive buffer full, bit 2 receive overrun, bit 3 transmit done, bit 4 transmit buffer changed (event inputs `ev_pulse[0..4]`), bit 5 receive not empty (`rx_avail`). An event high at a clock edge with its mask bit clear sets its status bit at that edge.
- R2: An event whose mask bit is set at that edge leaves the status bit unchanged, and clearing the mask later does not make the event appear.
- R3: A write to word address 0 clears every status bit written as 1 and keeps the others. Reading address 0 returns the status in bits 5:0.
- R4: A write to address 1 ORs the data into the enable register. A write to address 2 clears the enable bits written as 1. Reading either address returns the enable value.
- R5: The mask register uses address 3 to set bits and address 4 to clear bits. Reading either address returns the mask value.
- R6: `irq_o` is high exactly when some status bit and its enable bit are both 1, with no extra cycle of delay after the registers change.
- R7: While `rx_avail` is high and mask bit 5 is clear, status bit 5 is set again at every edge, even right after software clears it.
- R8: When a hardware set and a host clear hit the same status bit at one edge, the bit ends up set.
- R9: Reset clears status, enable and mask and holds `irq_o` low.
- R10: Addresses 5 to 7 read as zero and writes to them change nothing. Bits 31:6 of every read are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ev_pulse | input | 5 | Event pulses, status bits 4:0 |
| rx_avail | input | 1 | Receive buffer not empty level |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench targets the edge where a host clear and a hardware set meet on one bit. A design that lets the clear win loses that event. It also checks that masking blocks latching rather than only gating the output: a design that gates only the output would show the event once the mask is lifted. Further directed cases cover the receive-not-empty level coming straight back after it is cleared, a clear-address write next to a set-address write, and writes to unmapped addresses. A decoder that aliased addresses would corrupt enable or mask in those cases. Random traffic mixes all of these against a register model kept in the bench.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int STAT_W    = 6;
  localparam int NUM_PULSE = STAT_W - 1;
  // Status bit positions: software decodes these.
  localparam int B_RX_DONE = 0;
  localparam int B_RX_FULL = 1;
  localparam int B_RX_OVR  = 2;
  localparam int B_TX_DONE = 3;
  localparam int B_TX_BUF  = 4;
  localparam int B_RX_NE   = 5;
  // Word addresses
  localparam int A_STAT    = 0;
  localparam int A_EN_SET  = 1;
  localparam int A_EN_CLR  = 2;
  localparam int A_MSK_SET = 3;
  localparam int A_MSK_CLR = 4;

  typedef logic [STAT_W-1:0] stat_t;

  // Events that may latch: the mask blocks recording.
  function automatic stat_t latch_fn(stat_t raw, stat_t mask);
    return raw & ~mask;
  endfunction

  // Clear first, then set: a set in the same cycle wins.
  function automatic stat_t setclr_next(stat_t cur, stat_t set, stat_t clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic any_pending(stat_t st, stat_t en);
    return |(st & en);
  endfunction
endpackage

// File: rtl/evt_irq_setclr.sv
module evt_irq_setclr
  import evt_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t set_i,
  input  stat_t clr_i,
  output stat_t q_o
);
  stat_t q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= (q_r | set_i) & ~clr_i;
  end

  assign q_o = q_r;

  // R4 for the enable instance, R5 for the mask instance
  assert_set_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & ~clr_i) != '0) |=> ((q_r & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));
  assert_clr_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((q_r & $past(clr_i)) == '0));
endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status
  import evt_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t raw_i,
  input  stat_t mask_i,
  input  stat_t clr_i,
  output stat_t q_o,
  output stat_t latch_o
);
  stat_t st_q;
  stat_t st_d;
  stat_t set_eff;

  assign set_eff = latch_fn(raw_i, mask_i);
  assign st_d    = setclr_next(st_q, set_eff, clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign q_o     = st_q;
  assign latch_o = set_eff;

  assert_mask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_d & ~st_q & mask_i) == '0));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_eff != '0) |=> ((st_q & $past(set_eff)) == $past(set_eff)));
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_eff) != '0) |=> ((st_q & $past(clr_i & ~set_eff)) == '0));
  assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & ~clr_i) != '0) |=> ((st_q & $past(st_q & ~clr_i)) == $past(st_q & ~clr_i)));
  assert_rx_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_i[B_RX_NE] && !mask_i[B_RX_NE]) |=> st_q[B_RX_NE]);
endmodule

// File: rtl/evt_irq_decode.sv
module evt_irq_decode
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  stat_t             st_i,
  input  stat_t             en_i,
  input  stat_t             mk_i,
  output stat_t             st_clr_o,
  output stat_t             en_set_o,
  output stat_t             en_clr_o,
  output stat_t             mk_set_o,
  output stat_t             mk_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_W = DATA_W - STAT_W;

  stat_t wbits;
  stat_t rsel;
  logic  unused_wdata_hi;

  assign wbits           = wdata_i[STAT_W-1:0];
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:STAT_W];

  function automatic stat_t hit(logic wr, logic [ADDR_W-1:0] a, int target, stat_t d);
    return (wr && (a == ADDR_W'(target))) ? d : '0;
  endfunction

  assign st_clr_o = hit(wr_i, addr_i, A_STAT,    wbits);
  assign en_set_o = hit(wr_i, addr_i, A_EN_SET,  wbits);
  assign en_clr_o = hit(wr_i, addr_i, A_EN_CLR,  wbits);
  assign mk_set_o = hit(wr_i, addr_i, A_MSK_SET, wbits);
  assign mk_clr_o = hit(wr_i, addr_i, A_MSK_CLR, wbits);

  always_comb begin
    rsel = '0;
    if (addr_i == ADDR_W'(A_STAT))                                        rsel = st_i;
    else if (addr_i == ADDR_W'(A_EN_SET)  || addr_i == ADDR_W'(A_EN_CLR))  rsel = en_i;
    else if (addr_i == ADDR_W'(A_MSK_SET) || addr_i == ADDR_W'(A_MSK_CLR)) rsel = mk_i;
  end

  assign rdata_o = {{PAD_W{1'b0}}, rsel};

  // R10: at most one register is written per access
  assert_one_target_R10: assert final ($countones({|st_clr_o, |en_set_o, |en_clr_o,
                                                   |mk_set_o, |mk_clr_o}) <= 1);
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_PULSE-1:0] ev_pulse,
  input  logic                 rx_avail,
  output logic                 irq_o
);
  stat_t raw_ev, st_q, en_q, mk_q, latched;
  stat_t st_clr, en_set, en_clr, mk_set, mk_clr;

  assign raw_ev = {rx_avail, ev_pulse};

  evt_irq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .st_i(st_q), .en_i(en_q), .mk_i(mk_q),
    .st_clr_o(st_clr), .en_set_o(en_set), .en_clr_o(en_clr),
    .mk_set_o(mk_set), .mk_clr_o(mk_clr), .rdata_o(bus_rdata)
  );

  evt_irq_setclr u_en (
    .clk(clk), .rst_n(rst_n), .set_i(en_set), .clr_i(en_clr), .q_o(en_q)
  );

  evt_irq_setclr u_mk (
    .clk(clk), .rst_n(rst_n), .set_i(mk_set), .clr_i(mk_clr), .q_o(mk_q)
  );

  evt_irq_status u_st (
    .clk(clk), .rst_n(rst_n), .raw_i(raw_ev), .mask_i(mk_q),
    .clr_i(st_clr), .q_o(st_q), .latch_o(latched)
  );

  assign irq_o = any_pending(st_q, en_q);

  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (st_q != '0 && en_q != '0));
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |-> (!irq_o && st_q == '0));
  assert_masked_no_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((latched & mk_q) == '0));
endmodule

// File: tb/evt_irq_ctrl_bench.sv
`timescale 1ns/1ps
module evt_irq_ctrl_bench;
  localparam int CLK_NS = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [4:0]  ev_pulse = 0;
  logic        rx_avail = 0;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [5:0] m_stat = 0, m_en = 0, m_mask = 0;

  always #(CLK_NS/2) clk = ~clk;

  evt_irq_ctrl u_evt_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pulse(ev_pulse),
    .rx_avail(rx_avail), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_read(logic [2:0] a);
    case (a)
      3'd0:       return {26'd0, m_stat};
      3'd1, 3'd2: return {26'd0, m_en};
      3'd3, 3'd4: return {26'd0, m_mask};
      default:    return 32'd0;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] a);
    case (a)
      3'd0:       return "R3";
      3'd1, 3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      default:    return "R10";
    endcase
  endfunction

  task automatic check_all(string tag);
    for (int a = 0; a < 8; a++) begin
      bus_addr = 3'(a);
      #0.4;
      total++;
      if (bus_rdata !== exp_read(3'(a))) begin
        bad++;
        $display("FAIL %s/%s addr=%0d got=%h exp=%h", tag, req_of(3'(a)), a,
                 bus_rdata, exp_read(3'(a)));
      end
    end
    total++;
    if (irq_o !== |(m_stat & m_en)) begin
      bad++;
      $display("FAIL %s/R6 irq got=%b exp=%b", tag, irq_o, |(m_stat & m_en));
    end
    bus_addr = 0;
  endtask

  // One clock of stimulus, model update, then full readback.
  task automatic step(logic [4:0] ev, logic rx, logic wr, logic [2:0] a,
                      logic [31:0] d, string tag);
    logic [5:0] set, clr, w;
    ev_pulse = ev; rx_avail = rx; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    w   = d[5:0];
    set = {rx, ev} & ~m_mask;
    clr = (wr && a == 3'd0) ? w : 6'd0;
    m_stat = (m_stat & ~clr) | set;
    if (wr) begin
      case (a)
        3'd1: m_en   = m_en | w;
        3'd2: m_en   = m_en & ~w;
        3'd3: m_mask = m_mask | w;
        3'd4: m_mask = m_mask & ~w;
        default: ;
      endcase
    end
    @(negedge clk);
    bus_wr = 0; ev_pulse = 0;
    check_all(tag);
  endtask

  task automatic do_reset(string tag);
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    m_stat = 0; m_en = 0; m_mask = 0;
    check_all(tag);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1a7e));
    @(negedge clk);
    do_reset("R9 reset");
    step(5'b00001, 0, 0, 0, 0, "R1 rx done");
    step(5'b10000, 0, 0, 0, 0, "R1 txbuf");
    step(0, 0, 1, 3'd1, 32'h0000_0001, "R4 en set");
    step(0, 0, 1, 3'd1, 32'hFFFF_FF08, "R4 en set wide");
    step(0, 0, 1, 3'd2, 32'h0000_0008, "R4 en clr");
    step(0, 0, 1, 3'd3, 32'h0000_0002, "R5 mask set");
    step(5'b00010, 0, 0, 0, 0, "R2 masked event");
    step(0, 0, 1, 3'd4, 32'h0000_0002, "R2 unmask no reveal");
    step(5'b01000, 0, 0, 0, 0, "R1 tx done");
    step(0, 0, 1, 3'd0, 32'h0000_0001, "R3 clear one");
    step(5'b01000, 0, 1, 3'd0, 32'h0000_0018, "R8 set beats clear");
    step(0, 1, 0, 0, 0, "R7 rx level");
    step(0, 1, 1, 3'd0, 32'h0000_0020, "R7 clear while level");
    step(0, 1, 1, 3'd3, 32'h0000_0020, "R7 mask level");
    step(0, 1, 1, 3'd0, 32'h0000_0020, "R7 masked clear");
    step(0, 1, 0, 0, 0, "R7 stays clear");
    step(0, 0, 1, 3'd6, 32'hFFFF_FFFF, "R10 unmapped write");
    step(0, 0, 1, 3'd5, 32'hFFFF_FFFF, "R10 unmapped write 5");
    step(0, 0, 1, 3'd1, 32'h0000_003F, "R6 enable all");
    do_reset("R9 mid reset");
    for (int i = 0; i < 600; i++) begin
      logic [4:0]  ev;
      logic        rx, wr;
      logic [2:0]  a;
      logic [31:0] d;
      ev = ($urandom % 3 == 0) ? 5'($urandom) : 5'd0;
      rx = ($urandom % 4 == 0);
      wr = ($urandom % 2 == 0);
      a  = 3'($urandom % 8);
      d  = $urandom;
      step(ev, rx, wr, a, d, "random");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule